// File: doc/BRIEF.md
# Stuffable Gated Clock Enable Generator

This block turns a nominal base-rate tick into a stream of gated clock enables. Each enable stands for one bit period. A read-side elastic store advances its read address on every enable. When the store's control logic finds the read address drifting from the write address, it sends a positive or a negative stuff command. A positive command adds one enable and a negative command removes one. The base tick itself is never retuned. Stuffing only changes how many enables come out, and only inside a designated overhead position of the multiplex frame.

A command is held until the frame reaches the overhead position. The block carries it out there and then pulses an acknowledge. An added enable is placed on a system cycle inside the overhead position that carries no base tick. A removed enable is taken by suppressing the first base tick that falls inside that position. At most one stuff action happens per overhead visit, so at most one per frame. The frame position is an input, because frame generation belongs to a neighbouring block.

Top module: `gstuff_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `gclk_en` and `stuff_ack` are 0.
- R2: With no stuff action taking place, `gclk_en` equals `base_tick` delayed by exactly one system cycle.
- R3: After a positive command (`stuff_pos`=1, `stuff_neg`=0) is registered, the first cycle with `frame_pos` equal to `OVH_POS` and `base_tick`=0 yields, one cycle later, `gclk_en`=1 together with `stuff_ack`=1. If every cycle of the overhead position carries a base tick, the addition waits for a later frame.
- R4: After a negative command (`stuff_neg`=1, `stuff_pos`=0) is registered, the first cycle with `frame_pos` equal to `OVH_POS` and `base_tick`=1 yields, one cycle later, `gclk_en`=0 together with `stuff_ack`=1. If the overhead position carries no base tick, the deletion waits for a later frame.
- R5: A cycle with `stuff_pos` and `stuff_neg` both at 1 creates no request. It leaves the output stream equal to the plain base tick stream.
- R6: A request registered outside the overhead position has no effect on `gclk_en` until the overhead position is reached.
- R7: At most one stuff action, and so one `stuff_ack` pulse, happens during one uninterrupted run of cycles with `frame_pos` equal to `OVH_POS`.
- R8: Commands that arrive while a request is still pending are ignored. The pending request keeps its direction until it is carried out.
- R9: Over any run, the number of `gclk_en` pulses equals the number of base ticks plus the performed additions minus the performed deletions. `stuff_ack` pulses only on a cycle that carries out an action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | Nominal base-rate tick, one system cycle wide |
| stuff_pos | input | 1 | Positive stuff command: add one enable |
| stuff_neg | input | 1 | Negative stuff command: remove one enable |
| frame_pos | input | POS_W | Current position in the multiplex frame |
| gclk_en | output | 1 | Gated clock enable, registered |
| stuff_ack | output | 1 | One-cycle pulse marking a performed stuff action |

## Verification
The bench builds the block with `POS_W`=3 and `OVH_POS`=5. Each frame position lasts four system cycles, so a whole frame is 32 cycles and the overhead position is a short four-cycle window. This brings within reach many frames per run, several commands racing for one window, and overhead windows that are saturated with ticks or empty of them. Those windows force additions and deletions to roll over to a later frame.

// File: rtl/gstuff_pkg.sv
package gstuff_pkg;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_ADD  = 2'd1,
    REQ_DEL  = 2'd2
  } req_e;

  // A new command is taken only when nothing is pending; conflicting commands cancel.
  function automatic req_e capture_req(input req_e cur, input logic p, input logic n);
    if (cur != REQ_NONE) return cur;
    if (p && !n)         return REQ_ADD;
    if (n && !p)         return REQ_DEL;
    return REQ_NONE;
  endfunction

  // An extra enable needs an idle system cycle inside a free overhead window.
  function automatic logic add_ok(input req_e r, input logic win, input logic used,
                                  input logic tick);
    return (r == REQ_ADD) && win && !used && !tick;
  endfunction

  // A deletion swallows a base tick that falls inside a free overhead window.
  function automatic logic del_ok(input req_e r, input logic win, input logic used,
                                  input logic tick);
    return (r == REQ_DEL) && win && !used && tick;
  endfunction

endpackage

// File: rtl/gstuff_req_hold.sv
module gstuff_req_hold
  import gstuff_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stuff_pos,
  input  logic stuff_neg,
  input  logic served,
  output req_e pend
);

  req_e pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      pend_q <= REQ_NONE;
    else if (served) pend_q <= REQ_NONE;
    else             pend_q <= capture_req(pend_q, stuff_pos, stuff_neg);
  end

  assign pend = pend_q;

  // R5
  both_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == REQ_NONE && stuff_pos && stuff_neg) |=> (pend_q == REQ_NONE));

  // R8
  pending_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != REQ_NONE && !served) |=> $stable(pend_q));

endmodule

// File: rtl/gstuff_slot_gate.sv
module gstuff_slot_gate
  import gstuff_pkg::*;
#(
  parameter int POS_W   = 4,
  parameter int OVH_POS = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] frame_pos,
  input  logic             base_tick,
  input  req_e             pend,
  output logic             in_ovh,
  output logic             add_act,
  output logic             del_act
);

  localparam logic [POS_W-1:0] OvhCode = POS_W'(OVH_POS);

  logic used_q;

  assign in_ovh  = (frame_pos == OvhCode);
  assign add_act = add_ok(pend, in_ovh, used_q, base_tick);
  assign del_act = del_ok(pend, in_ovh, used_q, base_tick);

  // One action per visit of the overhead window; cleared when the window ends.
  always_ff @(posedge clk) begin
    if (!rst_n)       used_q <= 1'b0;
    else if (!in_ovh) used_q <= 1'b0;
    else              used_q <= used_q | add_act | del_act;
  end

  // R7
  one_per_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (add_act || del_act) |=> !(add_act || del_act));

  // R3
  add_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_act |-> (!base_tick && in_ovh));

  // R4
  del_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    del_act |-> (base_tick && in_ovh));

  // R7
  no_dual_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(add_act && del_act));

endmodule

// File: rtl/gstuff_gen.sv
module gstuff_gen
  import gstuff_pkg::*;
#(
  parameter int POS_W   = 4,
  parameter int OVH_POS = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_tick,
  input  logic             stuff_pos,
  input  logic             stuff_neg,
  input  logic [POS_W-1:0] frame_pos,
  output logic             gclk_en,
  output logic             stuff_ack
);

  req_e pend_w;
  logic in_ovh_w;
  logic add_act_w;
  logic del_act_w;
  logic served_w;

  assign served_w = add_act_w | del_act_w;

  gstuff_req_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .stuff_pos (stuff_pos),
    .stuff_neg (stuff_neg),
    .served    (served_w),
    .pend      (pend_w)
  );

  gstuff_slot_gate #(
    .POS_W   (POS_W),
    .OVH_POS (OVH_POS)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_pos (frame_pos),
    .base_tick (base_tick),
    .pend      (pend_w),
    .in_ovh    (in_ovh_w),
    .add_act   (add_act_w),
    .del_act   (del_act_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gclk_en   <= 1'b0;
      stuff_ack <= 1'b0;
    end else begin
      gclk_en   <= (base_tick & ~del_act_w) | add_act_w;
      stuff_ack <= served_w;
    end
  end

  // R9
  ack_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stuff_ack) |-> $past(in_ovh_w));

  // R2
  plain_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !served_w |=> (gclk_en == $past(base_tick)));

endmodule

// File: tb/test_gstuff_gen.sv
`timescale 1ns/1ps
module test_gstuff_gen;

  localparam int POS_W   = 3;
  localparam int OVH_POS = 5;
  localparam int DWELL   = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             base_tick = 1'b0;
  logic             stuff_pos = 1'b0;
  logic             stuff_neg = 1'b0;
  logic [POS_W-1:0] frame_pos = '0;
  logic             gclk_en;
  logic             stuff_ack;

  always #4 clk = ~clk;

  gstuff_gen #(.POS_W(POS_W), .OVH_POS(OVH_POS)) i_gstuff_gen (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .stuff_pos(stuff_pos),
    .stuff_neg(stuff_neg), .frame_pos(frame_pos), .gclk_en(gclk_en),
    .stuff_ack(stuff_ack)
  );

  int    vecs = 0;
  int    errs = 0;
  int    cyc = 0;
  int    tick_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  string ph = "R2";
  bit    finished = 1'b0;

  // behavioural model state: 0 none, 1 add, 2 delete
  int m_pend = 0;
  bit m_used = 1'b0;
  int n_ticks = 0, n_adds = 0, n_dels = 0, n_gclk = 0;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual %0b expected %0b (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic step(input bit p, input bit n);
    bit t, win, addx, delx, eg, ea;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    t = (tick_mode == 1) ? 1'b1 : (tick_mode == 2) ? 1'b0 : (lfsr[0] & lfsr[3]);
    base_tick = t;
    stuff_pos = p;
    stuff_neg = n;
    frame_pos = POS_W'((cyc / DWELL) % (1 << POS_W));
    win  = (int'(frame_pos) == OVH_POS);
    addx = (m_pend == 1) && win && !m_used && !t;
    delx = (m_pend == 2) && win && !m_used && t;
    eg   = (t && !delx) || addx;
    ea   = addx || delx;
    if (addx || delx) m_pend = 0;
    else if (m_pend == 0) begin
      if (p && !n) m_pend = 1;
      else if (n && !p) m_pend = 2;
    end
    m_used = win ? (m_used || addx || delx) : 1'b0;
    n_ticks += int'(t);
    n_adds  += int'(addx);
    n_dels  += int'(delx);
    @(posedge clk);
    @(negedge clk);
    cyc++;
    n_gclk += int'(gclk_en === 1'b1);
    chk(ph, "gclk_en", gclk_en, eg);
    chk(ph, "stuff_ack", stuff_ack, ea);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 8);
    errs++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    if (!finished) $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "gclk_en in reset", gclk_en, 1'b0);
    chk("R1", "stuff_ack in reset", stuff_ack, 1'b0);
    rst_n = 1'b1;
    ph = "R1"; step(1'b0, 1'b0);

    ph = "R2"; idle(96);

    ph = "R3"; step(1'b1, 1'b0); idle(80);
    // R6: request far from the window waits for it
    ph = "R6"; idle(2); step(1'b1, 1'b0); idle(40);

    ph = "R4"; step(1'b0, 1'b1); idle(80);

    // R3 corner: window full of ticks, addition rolls over
    ph = "R3"; tick_mode = 1; step(1'b1, 1'b0); idle(70);
    tick_mode = 0; idle(70);

    // R4 corner: window without ticks, deletion rolls over
    ph = "R4"; tick_mode = 2; step(1'b0, 1'b1); idle(70);
    tick_mode = 1; idle(40);
    tick_mode = 0;

    ph = "R5"; step(1'b1, 1'b1); idle(64);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1);

    ph = "R8"; step(1'b1, 1'b0); step(1'b0, 1'b1); step(1'b0, 1'b1); idle(64);
    ph = "R8"; step(1'b0, 1'b1); for (int i = 0; i < 10; i++) step(1'b1, 1'b0); idle(64);

    // R7: requests refill every cycle, only one action per window
    ph = "R7";
    for (int i = 0; i < 256; i++) step(1'b1, 1'b0);
    tick_mode = 1;
    for (int i = 0; i < 128; i++) step(1'b0, 1'b1);
    tick_mode = 0;
    for (int i = 0; i < 256; i++) step(i[0], !i[0]);
    idle(40);

    // R9: pulse balance over the whole run
    vecs++;
    if (n_gclk != n_ticks + n_adds - n_dels || n_adds == 0 || n_dels == 0) begin
      errs++;
      $display("FAIL R9 enable count actual %0d expected %0d (adds %0d dels %0d)",
               n_gclk, n_ticks + n_adds - n_dels, n_adds, n_dels);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule